// File: doc/BRIEF.md
# Packed Float to Saturated Integer Converter

This block takes a 64-bit operand that holds two single-precision floating-point values, one in each 32-bit lane. It turns each value into a signed integer by truncating toward zero. Values that fall outside the target range are clamped to the nearest limit. An 8-bit suffix picks the target width:

- **Narrow mode** gives a 16-bit integer. It sits in the low half of its own lane, and the upper half of that lane is cleared.
- **Wide mode** gives a 32-bit integer that fills the whole lane.
- **Any other suffix** selects no mode, and the result is all zeros.

The result is held in a single register stage. The valid output follows the input strobe one clock later.

The suffix decoder has three outcomes, and each input strobe takes exactly one of them:

- **MODE_NONE**: the suffix is neither code. A zero result is captured.
- **MODE_NARROW**: the suffix is 0x1C. The 16-bit clamp is applied per lane.
- **MODE_WIDE**: the suffix is 0x1D. The 32-bit clamp is applied per lane.

The decoder keeps no state. Each strobe passes straight from decode to the result register. When no strobe is present, the register keeps its last value.

Top module: `fcvt_packed_f2i`

## Requirements
- R1: Operand bits 31:0 and 63:32 are each converted as an independent float, and each lane's result is written only into the same lane of out_result.
- R2: In narrow mode, a lane value of 2^15 or more gives 0x7FFF in the lane's low 16 bits.
- R3: In narrow mode, a lane value of -2^15 or less gives 0x8000 in the lane's low 16 bits.
- R4: An in-range value is truncated toward zero (for example -1.7 gives -1 and 0.9 gives 0). In narrow mode it is placed in bits 15:0 for the low lane and bits 47:32 for the high lane.
- R5: In narrow mode, result bits 31:16 and 63:48 are always zero, including on saturation.
- R6: Suffix 0x1C selects narrow mode and suffix 0x1D selects wide mode.
- R7: In wide mode, a lane value of 2^31 or more gives 0x7FFFFFFF, and a value of -2^31 or less gives 0x80000000, across the whole lane.
- R8: Zeros of either sign and denormals (exponent field 0) convert to 0. Infinities and NaNs (exponent field all ones) saturate toward the limit that matches their sign bit.
- R9: out_valid equals in_valid delayed by one clock. out_result is updated only on a clock where in_valid was high and is otherwise held.
- R10: Any suffix other than 0x1C and 0x1D yields an all-zero result with out_valid still asserted.
- R11: While rst_n is low, out_valid and out_result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and suffix are valid this cycle |
| in_suffix | input | 8 | Mode select byte |
| in_operand | input | 64 | Two packed single-precision floats |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_result | output | 64 | Two converted lanes |

## Verification
The bench builds the block with its default parameters: two lanes of 8-bit exponent and 23-bit mantissa, with a 16-bit narrow target. With these values, every exponent code can be swept in both signs, in both modes, under six mantissa patterns. This covers each point where truncation turns into saturation, the denormal band and the all-ones exponent.

The two lanes carry different exponents in every vector, so a lane swap or a cross-lane leak shows up. A full sweep of all 256 suffix bytes covers the zero result for unknown codes. Hand-picked values cover the boundaries themselves: 32767, 32768, -32768, -32769, -1.7 and 0.9.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam logic [7:0] SUF_NARROW = 8'h1C;
    localparam logic [7:0] SUF_WIDE   = 8'h1D;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_NARROW = 2'd1,
        MODE_WIDE   = 2'd2
    } mode_e;

endpackage

// File: rtl/fcvt_mode_decode.sv
module fcvt_mode_decode
    import fcvt_pkg::*;
(
    input  logic [7:0] suffix,
    output mode_e      mode
);

    always_comb begin
        case (suffix)
            SUF_NARROW: mode = MODE_NARROW;
            SUF_WIDE:   mode = MODE_WIDE;
            default:    mode = MODE_NONE;
        endcase
    end

endmodule

// File: rtl/fcvt_lane_trunc.sv
// One float lane truncated toward zero into a signed OUT_W integer with clamping.
module fcvt_lane_trunc #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 16
) (
    input  logic [EXP_W+MAN_W:0] flt,
    output logic [OUT_W-1:0]     res
);

    localparam int SIG_W   = MAN_W + 1;
    localparam int EXT_W   = SIG_W + OUT_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int SAT_EXP = BIAS + OUT_W - 1;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             sat;
    logic [EXT_W-1:0] ext;
    logic [OUT_W-1:0] mag;

    assign sgn = flt[EXP_W+MAN_W];
    assign ex  = flt[EXP_W+MAN_W-1:MAN_W];
    assign mn  = flt[MAN_W-1:0];

    always_comb begin
        // all-ones exponent (inf/NaN) or magnitude at/over 2^(OUT_W-1) clamps
        sat = (ex == '1) || (ex >= EXP_W'(SAT_EXP));
        ext = '0;
        mag = '0;
        if (!sat && (ex >= EXP_W'(BIAS))) begin
            ext = EXT_W'({1'b1, mn}) << (ex - EXP_W'(BIAS));
            mag = ext[MAN_W +: OUT_W];
        end
        if (sat)
            res = sgn ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
        else
            res = sgn ? (~mag + 1'b1) : mag;
    end

endmodule

// File: rtl/fcvt_lane_pack.sv
module fcvt_lane_pack
    import fcvt_pkg::*;
#(
    parameter int LANE_W   = 32,
    parameter int NARROW_W = 16
) (
    input  mode_e               mode,
    input  logic [NARROW_W-1:0] n_res,
    input  logic [LANE_W-1:0]   w_res,
    output logic [LANE_W-1:0]   lane_out
);

    always_comb begin
        unique case (mode)
            MODE_NARROW: lane_out = LANE_W'(n_res);
            MODE_WIDE:   lane_out = w_res;
            default:     lane_out = '0;
        endcase
    end

endmodule

// File: rtl/fcvt_packed_f2i.sv
module fcvt_packed_f2i
    import fcvt_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter int NARROW_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [7:0]                    in_suffix,
    input  logic [LANES*(1+EXP_W+MAN_W)-1:0] in_operand,
    output logic                          out_valid,
    output logic [LANES*(1+EXP_W+MAN_W)-1:0] out_result
);

    localparam int LANE_W = 1 + EXP_W + MAN_W;
    localparam int DATA_W = LANES * LANE_W;

    mode_e             mode;
    logic [DATA_W-1:0] next_result;

    fcvt_mode_decode u_dec (
        .suffix (in_suffix),
        .mode   (mode)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [NARROW_W-1:0] n_res;
        logic [LANE_W-1:0]   w_res;

        fcvt_lane_trunc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(NARROW_W)) u_narrow (
            .flt (in_operand[g*LANE_W +: LANE_W]),
            .res (n_res)
        );

        fcvt_lane_trunc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(LANE_W)) u_wide (
            .flt (in_operand[g*LANE_W +: LANE_W]),
            .res (w_res)
        );

        fcvt_lane_pack #(.LANE_W(LANE_W), .NARROW_W(NARROW_W)) u_pack (
            .mode     (mode),
            .n_res    (n_res),
            .w_res    (w_res),
            .lane_out (next_result[g*LANE_W +: LANE_W])
        );

        // R2/R3: a positive lane never yields a negative narrow value
        p_sign_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !in_operand[g*LANE_W + LANE_W - 1] |-> !n_res[NARROW_W-1]);

        // R5: narrow mode leaves the upper half of each lane clear
        p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_suffix == SUF_NARROW)
            |=> out_result[g*LANE_W + NARROW_W +: LANE_W-NARROW_W] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (in_valid) begin
            out_result <= next_result;
        end
    end

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_result == $past(out_result)));

    p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_suffix != SUF_NARROW && in_suffix != SUF_WIDE)
        |=> (out_valid && out_result == '0));

endmodule

// File: tb/sim_fcvt_packed_f2i.sv
module sim_fcvt_packed_f2i;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_suffix = 8'h00;
    logic [63:0] in_operand = 64'h0;
    logic        out_valid;
    logic [63:0] out_result;

    int vecs = 0;
    int bad  = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    fcvt_packed_f2i u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_suffix  (in_suffix),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        vecs++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    // Expected lane value, from the stated conversion rules.
    function automatic logic [31:0] ref_lane(input logic [31:0] f, input bit wide);
        logic        s = f[31];
        int          e = int'(f[30:23]);
        longint      mag;
        longint      val;
        int          lim = wide ? 31 : 15;
        if (e == 255 || e >= 127 + lim) begin
            if (wide) return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
            return s ? 32'h0000_8000 : 32'h0000_7FFF;
        end
        if (e < 127) return 32'h0;
        mag = longint'({1'b1, f[22:0]});
        mag = (mag << (e - 127)) >>> 23;
        val = s ? -mag : mag;
        if (wide) return val[31:0];
        return {16'h0, val[15:0]};
    endfunction

    function automatic string tag_of(input logic [31:0] f, input bit wide);
        int e = int'(f[30:23]);
        if (e == 0 || e == 255) return "R8";
        if (wide && e >= 158) return "R7";
        if (!wide && e >= 142) return f[31] ? "R3" : "R2";
        return "R4";
    endfunction

    // Drive one strobe; return the captured result one clock later.
    task automatic issue(input logic [63:0] op, input logic [7:0] suf, output logic [63:0] res);
        @(negedge clk);
        in_valid   = 1'b1;
        in_suffix  = suf;
        in_operand = op;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 valid", {63'h0, out_valid}, 64'h1);
        res = out_result;
    endtask

    task automatic pair(input logic [31:0] hi, input logic [31:0] lo, input bit wide, input string tag);
        logic [63:0] r;
        issue({hi, lo}, wide ? 8'h1D : 8'h1C, r);
        check(tag, r, {ref_lane(hi, wide), ref_lane(lo, wide)});
        if (!wide) check("R5 upper", r & 64'hFFFF0000_FFFF0000, 64'h0);
    endtask

    initial begin
        logic [63:0] r;
        logic [63:0] held;
        logic [22:0] mpat [6];
        mpat[0] = 23'h000000; mpat[1] = 23'h000001; mpat[2] = 23'h400000;
        mpat[3] = 23'h7FFFFF; mpat[4] = 23'h2AAAAA; mpat[5] = 23'h155555;

        repeat (3) @(negedge clk);
        check("R11 valid", {63'h0, out_valid}, 64'h0);
        check("R11 result", out_result, 64'h0);
        rst_n = 1'b1;

        // Boundary values, narrow mode
        pair(32'h46FFFE00, 32'h47000000, 1'b0, "R2");        // 32767, 32768
        pair(32'hC7000000, 32'hC7000100, 1'b0, "R3");        // -32768, -32769
        pair(32'hBFD9999A, 32'h3F666666, 1'b0, "R4");        // -1.7, 0.9
        issue({32'hBFD9999A, 32'h3F666666}, 8'h1C, r);
        check("R4 trunc", r, 64'h0000FFFF_00000000);
        pair(32'h80000000, 32'h00000000, 1'b0, "R8 zeros");
        pair(32'hFF800000, 32'h7F800000, 1'b0, "R8 inf");
        pair(32'hFFC00001, 32'h7FC00000, 1'b0, "R8 nan");
        // Wide mode boundaries
        pair(32'hCF000000, 32'h4F000000, 1'b1, "R7");        // -2^31, 2^31
        pair(32'h4EFFFFFF, 32'hCEFFFFFF, 1'b1, "R7 inrange");
        // Lane independence: only one lane nonzero
        issue({32'h00000000, 32'h42F60000}, 8'h1C, r);       // 123.0 in low lane
        check("R1 low", r, 64'h00000000_0000007B);
        issue({32'h42F60000, 32'h00000000}, 8'h1C, r);
        check("R1 high", r, 64'h0000007B_00000000);
        // Mode select: same operand, both codes
        issue({32'hC2F60000, 32'h47000000}, 8'h1C, r);
        check("R6 narrow", r, 64'h0000FF85_00007FFF);
        issue({32'hC2F60000, 32'h47000000}, 8'h1D, r);
        check("R6 wide", r, 64'hFFFFFF85_00008000);

        // Hold with no strobe
        held = out_result;
        @(negedge clk);
        check("R9 idle valid", {63'h0, out_valid}, 64'h0);
        in_operand = 64'h3F800000_3F800000;
        @(negedge clk);
        check("R9 hold", out_result, held);

        // Exponent / mantissa / sign sweep in both modes
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 6; k++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [31:0] lo = {s[0], e[7:0], mpat[k]};
                        logic [31:0] hi = {~s[0], 8'(255 - e), mpat[k] ^ 23'h0F0F0F};
                        pair(hi, lo, w[0], tag_of(lo, w[0]));
                    end
                end
            end
        end

        // Unknown suffix codes
        for (int c = 0; c < 256; c++) begin
            if (c != 8'h1C && c != 8'h1D) begin
                issue(64'h47000000_C2F60000, c[7:0], r);
                check("R10", r, 64'h0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 190000);
        if (!done) begin
            vecs++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule